// File: doc/BRIEF.md
# Nine-Level Slot PWM Encoder

This block sits behind the quantizer of a multibit noise-shaping modulator. Once per frame it takes a level from 0 to 8 and sends it out as a one-bit serial stream at the master-clock rate. A frame is eight master-clock cycles long, and the number of ones in it equals the level. With a 22.5792 MHz or 24.576 MHz master clock, the output is a single-bit stream at eight times the frame rate.

The run of ones can be moved to a pseudo-random position inside each frame. This spreads the spectral lines that a fixed pattern position would cause. A strap input holds the run at a fixed position instead. A second strap narrows the level set to the seven inner levels. With both straps low, every frame has at least one rising and one falling edge, so the edge density does not depend on the signal. A mute input replaces the stream with a balanced midscale pattern. A clip indicator stretches each integrator-clip pulse into a long visible flag.

Top module: `pwm9_enc`

## Requirements
- R1: While reset is held, `frameStart` is 1 and `clipFlag` is 0. The first frame after reset is the midscale pattern 1,0,1,0,1,0,1,0 (first bit first).
- R2: `frameStart` is high in exactly one cycle of every eight. That cycle carries the first bit of a frame, and every frame is eight cycles long.
- R3: `levelIn`, `muteIn`, `fixPosN` and `narrowN` are sampled in the last cycle of a frame and take effect in the next frame. With mute low and `narrowN` high, the frame holds exactly `levelIn` ones. Values 9 to 15 count as 8.
- R4: With `fixPosN` low (rotation off), a frame at level L is L ones followed by 8-L zeros. The first one is in the `frameStart` cycle.
- R5: With `fixPosN` high, the ones of a frame form one run that is contiguous when the frame is viewed as a circle. The run's starting slot comes from a 16-bit LFSR that advances once per frame, so the run takes several different positions over a sequence of frames at one level.
- R6: With `narrowN` low, level 0 becomes 1 and level 8 (or any larger value) becomes 7. Levels 1 to 7 pass unchanged.
- R7: With `fixPosN` and `narrowN` both low, every frame holds at least one 1 and at least one 0, for any level input.
- R8: With `muteIn` high, the frame is 1,0,1,0,1,0,1,0 whatever the level and the straps.
- R9: A cycle with `clipIn` high makes `clipFlag` high from the next cycle for exactly HOLD_CYCLES cycles. A new pulse during the hold restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one output bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| levelIn | input | 4 | Quantizer level for the next frame, 0 to 8 |
| muteIn | input | 1 | High forces the midscale pattern |
| fixPosN | input | 1 | Low keeps the run of ones at the frame start |
| narrowN | input | 1 | Low limits the levels to 1 through 7 |
| clipIn | input | 1 | Integrator clip pulse from the modulator |
| bitOut | output | 1 | Serial one-bit output stream |
| frameStart | output | 1 | High during the first bit of each frame |
| clipFlag | output | 1 | Stretched clip indicator |

## Verification
The count assertions assume `levelIn` never exceeds 8 when it is compared directly with the ones count. The stimulus only drives larger values in the frames that test clamping, and those frames are judged by the bench alone. All inputs are changed just after the negative edge that starts a frame and are held for the whole frame, so every pattern belongs to one set of inputs. The clip pulse is driven independently of the frame phase, because the hold counter does not depend on frames.

// File: rtl/pwm9_pkg.sv
package pwm9_pkg;
  localparam int SLOTS = 8;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LVL_W = $clog2(SLOTS + 1) + 1;

  typedef struct packed {
    logic loadFrame;
    logic frameStart;
  } ctlStrobe_t;

  function automatic logic [SLOTS-1:0] midPattern();
    logic [SLOTS-1:0] p;
    for (int i = 0; i < SLOTS; i++) p[i] = (i % 2) == 1;
    return p;
  endfunction
endpackage

// File: rtl/pwm9_ctl.sv
module pwm9_ctl
  import pwm9_pkg::*;
#(
  parameter int HOLD_CYCLES = 24_000_000,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic clipIn,
  output ctlStrobe_t strobe,
  output logic [SLOT_W-1:0] rotOffset,
  output logic clipFlag
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [15:0] lfsr;
  logic [HOLD_W-1:0] holdCnt;

  always_comb begin
    strobe.frameStart = (slotCnt == '0);
    strobe.loadFrame = (slotCnt == SLOT_W'(SLOTS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotCnt <= '0;
    else slotCnt <= slotCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else if (strobe.loadFrame) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  assign rotOffset = lfsr[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (clipIn) holdCnt <= HOLD_W'(HOLD_CYCLES);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign clipFlag = (holdCnt != '0);
endmodule

// File: rtl/pwm9_path.sv
module pwm9_path
  import pwm9_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctlStrobe_t strobe,
  input  logic [SLOT_W-1:0] rotOffset,
  input  logic [LVL_W-1:0] levelIn,
  input  logic muteIn,
  input  logic fixPosN,
  input  logic narrowN,
  output logic [SLOTS-1:0] patNext,
  output logic bitOut
);
  logic [LVL_W-1:0] lvlClamp;
  logic [LVL_W-1:0] lvlEff;
  logic [SLOTS-1:0] runBase;
  logic [2*SLOTS-1:0] runDouble;
  logic [SLOTS-1:0] runPlaced;
  logic [SLOTS-1:0] shReg;

  always_comb begin
    lvlClamp = (levelIn > LVL_W'(SLOTS)) ? LVL_W'(SLOTS) : levelIn;
    lvlEff = lvlClamp;
    if (!narrowN) begin
      if (lvlClamp == '0) lvlEff = LVL_W'(1);
      else if (lvlClamp == LVL_W'(SLOTS)) lvlEff = LVL_W'(SLOTS - 1);
    end
    runBase = ~({SLOTS{1'b1}} >> lvlEff);
    runDouble = {runBase, runBase} >> rotOffset;
    runPlaced = fixPosN ? runDouble[SLOTS-1:0] : runBase;
    patNext = muteIn ? midPattern() : runPlaced;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= midPattern();
    else if (strobe.loadFrame) shReg <= patNext;
    else shReg <= {shReg[SLOTS-2:0], 1'b0};
  end

  assign bitOut = shReg[SLOTS-1];
endmodule

// File: rtl/pwm9_enc.sv
module pwm9_enc
  import pwm9_pkg::*;
#(
  parameter int HOLD_CYCLES = 24_000_000,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [3:0] levelIn,
  input  logic muteIn,
  input  logic fixPosN,
  input  logic narrowN,
  input  logic clipIn,
  output logic bitOut,
  output logic frameStart,
  output logic clipFlag
);
  ctlStrobe_t strobe;
  logic [SLOT_W-1:0] rotOffset;
  logic [SLOTS-1:0] patNext;

  pwm9_ctl #(.HOLD_CYCLES(HOLD_CYCLES), .LFSR_SEED(LFSR_SEED)) ctl (
    .clk(clk), .rstN(rstN), .clipIn(clipIn),
    .strobe(strobe), .rotOffset(rotOffset), .clipFlag(clipFlag)
  );

  pwm9_path path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rotOffset(rotOffset),
    .levelIn(LVL_W'(levelIn)), .muteIn(muteIn), .fixPosN(fixPosN), .narrowN(narrowN),
    .patNext(patNext), .bitOut(bitOut)
  );

  assign frameStart = strobe.frameStart;
endmodule

// File: rtl/pwm9_enc_chk.sv
module pwm9_enc_chk
  import pwm9_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic loadFrame,
  input logic [SLOTS-1:0] patNext,
  input logic [3:0] levelIn,
  input logic muteIn,
  input logic fixPosN,
  input logic narrowN,
  input logic clipIn,
  input logic bitOut,
  input logic frameStart,
  input logic clipFlag
);
  // R2
  frame_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R3
  ones_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadFrame && !muteIn && narrowN && levelIn <= 4'(SLOTS)) |-> ($countones(patNext) == int'(levelIn)));

  // R7
  edge_guarantee_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadFrame && !muteIn && !fixPosN && !narrowN) |-> (patNext != '0 && patNext != '1));

  // R8
  mute_first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadFrame && muteIn) |=> (bitOut && frameStart));

  // R9
  clip_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    clipIn |=> clipFlag);
endmodule

bind pwm9_enc pwm9_enc_chk chk (
  .clk(clk), .rstN(rstN), .loadFrame(strobe.loadFrame), .patNext(patNext),
  .levelIn(levelIn), .muteIn(muteIn), .fixPosN(fixPosN), .narrowN(narrowN),
  .clipIn(clipIn), .bitOut(bitOut), .frameStart(frameStart), .clipFlag(clipFlag)
);

// File: tb/pwm9_enc_test.sv
module pwm9_enc_test;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] levelIn = 4'd4;
  logic muteIn = 1'b0;
  logic fixPosN = 1'b1;
  logic narrowN = 1'b1;
  logic clipIn = 1'b0;
  logic bitOut, frameStart, clipFlag;

  always #5 clk = ~clk;

  pwm9_enc #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rstN(rstN), .levelIn(levelIn), .muteIn(muteIn), .fixPosN(fixPosN),
    .narrowN(narrowN), .clipIn(clipIn), .bitOut(bitOut), .frameStart(frameStart),
    .clipFlag(clipFlag)
  );

  typedef struct {
    int tgt;
    bit exact;
    logic [7:0] pat;
    int ones;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int frameNo = 0;
  int nBits = 0;
  logic [7:0] cur = '0;
  bit seen[256];
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int popc(input logic [7:0] p);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(p[i]);
    return n;
  endfunction

  function automatic int runCount(input logic [7:0] p);
    int n = 0;
    for (int i = 0; i < 8; i++) if (p[i] && !p[(i + 7) % 8]) n++;
    return n;
  endfunction

  task automatic closeFrame();
    exp_t e;
    if (q.size() > 0 && q[0].tgt == frameNo) begin
      e = q.pop_front();
      if (e.exact) begin
        check(cur === e.pat, e.req, "frame pattern", int'(cur), int'(e.pat));
      end else begin
        check(popc(cur) == e.ones, "R3", "ones in rotated frame", popc(cur), e.ones);
        check(runCount(cur) == ((e.ones == 0 || e.ones == 8) ? 0 : 1), "R5", "circular runs",
              runCount(cur), 1);
        seen[cur] = 1'b1;
      end
      if (e.req == "R7")
        check(cur != 8'h00 && cur != 8'hFF, "R7", "frame has both bit values", int'(cur), 8'h55);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (frameStart) begin
        if (frameNo > 0) begin
          if (nBits != 8) check(1'b0, "R2", "frame length", nBits, 8);
          else closeFrame();
        end
        frameNo++;
        nBits = 0;
      end else if (nBits >= 8) begin
        check(1'b0, "R2", "missing frame start", nBits, 8);
        nBits = 0;
      end
      cur = {cur[6:0], bitOut};
      nBits++;
    end
  end

  task automatic send(input int lv, input bit m, input bit fx, input bit nr, input string req);
    exp_t e;
    int eff;
    @(negedge clk);
    while (!frameStart) @(negedge clk);
    #1;
    levelIn = 4'(lv);
    muteIn = m;
    fixPosN = fx;
    narrowN = nr;
    eff = (lv > 8) ? 8 : lv;
    if (!nr && eff == 0) eff = 1;
    if (!nr && eff == 8) eff = 7;
    e.tgt = frameNo + 1;
    e.ones = eff;
    e.req = req;
    e.exact = m || !fx;
    if (m) e.pat = 8'hAA;
    else e.pat = ~(8'hFF >> eff);
    q.push_back(e);
  endtask

  task automatic clipTest(input bit retrig);
    int highs = 0;
    bit again = 0;
    @(negedge clk);
    clipIn = 1'b1;
    @(negedge clk);
    clipIn = 1'b0;
    while (clipFlag) begin
      highs++;
      if (clipIn) clipIn = 1'b0;
      if (retrig && !again && highs == 10) begin
        clipIn = 1'b1;
        again = 1'b1;
      end
      @(negedge clk);
    end
    check(highs == (retrig ? 10 + HOLD : HOLD), "R9", "clip flag high cycles", highs,
          retrig ? 10 + HOLD : HOLD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int distinct;
    exp_t r;
    repeat (4) @(posedge clk);
    #1;
    check(frameStart === 1'b1, "R1", "frameStart in reset", int'(frameStart), 1);
    check(clipFlag === 1'b0, "R1", "clipFlag in reset", int'(clipFlag), 0);
    r.tgt = 1; r.exact = 1; r.pat = 8'hAA; r.ones = 4; r.req = "R1";
    q.push_back(r);
    @(posedge clk);
    #1 rstN = 1'b1;

    // R4: fixed position, every level
    for (int lv = 0; lv <= 8; lv++) send(lv, 0, 0, 1, "R4");
    // R3: values above 8 clamp to 8
    send(12, 0, 0, 1, "R3");
    send(15, 0, 0, 1, "R3");
    // R5: rotation at several levels
    for (int k = 0; k < 24; k++) send(3, 0, 1, 1, "R5");
    for (int lv = 0; lv <= 8; lv++) send(lv, 0, 1, 1, "R5");
    // R6: narrowed levels
    send(0, 0, 0, 0, "R6");
    send(8, 0, 0, 0, "R6");
    send(4, 0, 0, 0, "R6");
    send(13, 0, 0, 0, "R6");
    // R7: both straps low
    for (int lv = 0; lv <= 9; lv++) send(lv, 0, 0, 0, "R7");
    // R8: mute ignores level and straps
    send(8, 1, 1, 1, "R8");
    send(0, 1, 0, 0, "R8");
    send(1, 1, 1, 0, "R8");
    send(4, 0, 0, 1, "R4");
    repeat (30) @(negedge clk);

    check(q.size() == 0, "R2", "frames left unchecked", q.size(), 0);
    distinct = 0;
    for (int i = 0; i < 256; i++) if (seen[i] && popc(8'(i)) == 3) distinct++;
    check(distinct >= 3, "R5", "distinct run positions at level 3", distinct, 3);

    check(clipFlag === 1'b0, "R9", "clip flag idle", int'(clipFlag), 0);
    clipTest(0);
    clipTest(1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule